// File: doc/BRIEF.md
# Tiled RAM Key-Match Unit

The unit answers "which locations currently hold this key?" in a single memory read. It needs no scan over the entries. The storage is a grid of block-RAM-shaped tiles. Each tile keeps one presence bit for every pair of an 8-bit key value and one of 32 locations. A store writes exactly one bit, at the address formed by joining the key slice and the location number. A search reads one whole word, addressed by the key slice. That word carries one bit per location that holds the slice.

Keys wider than 8 bits are cut into byte slices. Each slice is looked up in its own column of tiles, and the column results are ANDed. Depths beyond 32 come from extra rows of tiles, whose results sit side by side in the match vector. A shadow copy of each location's key lets a rewrite erase the old presence bit before it sets the new one. A valid bit per location masks any location that has never been written.

Writes and searches each arrive on a valid/ready channel. A transfer happens on a clock edge where valid and ready are both high. The result leaves on a valid/ready channel too. While a result is held and `res_ready` is low, `srch_ready` is low and the result does not change. `wr_ready` drops for exactly one cycle after a rewrite is accepted. During that cycle, `srch_ready` is low for searches whose key is the old or the new key of that location.

Top module: `cam_tiled_lookup`

## Requirements
- R1: After reset, `res_valid` is 0, `wr_ready` and `srch_ready` are 1, and a search for any key reports no hit and an all-zero match vector.
- R2: A write to a location that has never been written completes at the edge where it is accepted. `wr_ready` is still 1 in the next cycle, and a search accepted at that next edge finds the location.
- R3: `res_valid` is 1 in the cycle after a search is accepted. In that result, bit i of `res_match` is 1 exactly when location i holds a written key equal to the searched key.
- R4: `res_hit` is 1 exactly when `res_match` is nonzero. `res_index` is the lowest set bit position of `res_match`, or 0 when there is no hit.
- R5: A write to a location that has already been written takes two edges, and `wr_ready` is 0 in the cycle between them. Afterwards the location matches only its new key.
- R6: In that in-between cycle, `srch_ready` is 0 when `srch_key` equals the old key or the new key of the location being rewritten. It stays 1 for other keys.
- R7: Matching compares every bit of the key. A stored key that differs from the searched key in only one byte slice does not match.
- R8: Locations in every tile row match. Location i appears at bit i of `res_match` for i of 32 and above too, and the lowest index is taken across rows.
- R9: While `res_valid` is 1 and `res_ready` is 0, `srch_ready` is 0 and `res_match`, `res_hit` and `res_index` hold their values.
- R10: A search accepted at the same edge as a write sees the stored state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high |
| wr_loc | input | $clog2(NUM_WORDS) | Location to write |
| wr_key | input | KEY_W | Key to store |
| srch_valid | input | 1 | Search request valid |
| srch_ready | output | 1 | Search accepted when high |
| srch_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Search result valid |
| res_ready | input | 1 | Result consumer ready |
| res_match | output | NUM_WORDS | One bit per matching location |
| res_hit | output | 1 | Any location matched |
| res_index | output | $clog2(NUM_WORDS) | Lowest matching location |

## Verification
Several keys are stored at separate locations, and one key is stored at two locations. This shows that a search returns every holder, and that the index picks the lower one. Some probe keys differ from a stored key in only the high byte or only the low byte. A column that ignored its result would show up as a false hit. Copies of one key are placed in both tile rows, and location 0 is added afterwards. This exposes a wrong row order or a wrong index across rows. Rewrites are probed in the one-cycle gap with the old key, the new key and an unrelated key, and again after the rewrite completes. These probes separate stall errors from stale presence bits. Searches issued at the same edge as a write, and searches held under back-pressure, cover the ordering rules.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Geometry of one RAM tile: key-slice bits and locations per tile.
  localparam int TILE_KEY_W = 8;
  localparam int TILE_DEPTH = 32;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_SET  = 1'b1
  } wseq_state_e;
endpackage

// File: rtl/cam_tile.sv
// One tile: 1-bit write port at address {key, loc}, DEPTH-wide read port at address key.
module cam_tile #(
  parameter int SLICE_W = 8,
  parameter int DEPTH   = 32,
  parameter int LOC_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLICE_W-1:0] wr_key,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic               wr_bit,
  input  logic               rd_en,
  input  logic [SLICE_W-1:0] rd_key,
  output logic [DEPTH-1:0]   rd_vec
);
  localparam int KEYS = 1 << SLICE_W;

  logic [DEPTH-1:0] bits_q [KEYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEYS; i++) bits_q[i] <= '0;
    end else if (wr_en) begin
      bits_q[wr_key][wr_loc] <= wr_bit;
    end
  end

  // Synchronous read, old data on a same-edge write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_vec <= '0;
    else if (rd_en) rd_vec <= bits_q[rd_key];
  end
endmodule

// File: rtl/cam_lowest_idx.sv
module cam_lowest_idx #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cam_write_seq.sv
// Write sequencer: shadow keys, valid bits, clear-then-set on rewrite.
module cam_write_seq
  import cam_pkg::*;
#(
  parameter int KEY_W     = 16,
  parameter int NUM_WORDS = 64,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [IDX_W-1:0]     wr_loc,
  input  logic [KEY_W-1:0]     wr_key,
  output logic                 mem_we,
  output logic [KEY_W-1:0]     mem_key,
  output logic [IDX_W-1:0]     mem_loc,
  output logic                 mem_bit,
  output logic [NUM_WORDS-1:0] loc_vld,
  output logic                 busy,
  output logic [KEY_W-1:0]     pend_old,
  output logic [KEY_W-1:0]     pend_new
);
  wseq_state_e      state_q;
  logic [KEY_W-1:0] shadow_q [NUM_WORDS];
  logic [IDX_W-1:0] pend_loc_q;
  logic             accept;

  assign busy     = (state_q == WS_SET);
  assign wr_ready = !busy;
  assign accept   = wr_valid && wr_ready;

  always_comb begin
    mem_we  = 1'b0;
    mem_key = wr_key;
    mem_loc = wr_loc;
    mem_bit = 1'b1;
    if (busy) begin
      mem_we  = 1'b1;
      mem_key = pend_new;
      mem_loc = pend_loc_q;
    end else if (accept) begin
      mem_we = 1'b1;
      if (loc_vld[wr_loc]) begin
        mem_key = shadow_q[wr_loc];
        mem_bit = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WS_IDLE;
      loc_vld    <= '0;
      pend_loc_q <= '0;
      pend_old   <= '0;
      pend_new   <= '0;
      for (int i = 0; i < NUM_WORDS; i++) shadow_q[i] <= '0;
    end else if (busy) begin
      loc_vld[pend_loc_q] <= 1'b1;
      state_q             <= WS_IDLE;
    end else if (accept) begin
      shadow_q[wr_loc] <= wr_key;
      if (loc_vld[wr_loc]) begin
        loc_vld[wr_loc] <= 1'b0;
        pend_loc_q      <= wr_loc;
        pend_old        <= shadow_q[wr_loc];
        pend_new        <= wr_key;
        state_q         <= WS_SET;
      end else begin
        loc_vld[wr_loc] <= 1'b1;
      end
    end
  end

  AST_SET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R5
  AST_VLD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !loc_vld[pend_loc_q]); // R5
  AST_FRESH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !loc_vld[wr_loc]) |=> (loc_vld[$past(wr_loc)] && !busy)); // R2
endmodule

// File: rtl/cam_tiled_lookup.sv
module cam_tiled_lookup
  import cam_pkg::*;
#(
  parameter int KEY_W     = 16,
  parameter int NUM_WORDS = 64,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [IDX_W-1:0]     wr_loc,
  input  logic [KEY_W-1:0]     wr_key,
  input  logic                 srch_valid,
  output logic                 srch_ready,
  input  logic [KEY_W-1:0]     srch_key,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [NUM_WORDS-1:0] res_match,
  output logic                 res_hit,
  output logic [IDX_W-1:0]     res_index
);
  // KEY_W must be a multiple of TILE_KEY_W, NUM_WORDS a multiple of TILE_DEPTH.
  localparam int COLS   = KEY_W / TILE_KEY_W;
  localparam int ROWS   = NUM_WORDS / TILE_DEPTH;
  localparam int TLOC_W = $clog2(TILE_DEPTH);

  logic                 mem_we, mem_bit, busy;
  logic [KEY_W-1:0]     mem_key, pend_old, pend_new;
  logic [IDX_W-1:0]     mem_loc;
  logic [NUM_WORDS-1:0] loc_vld, vld_snap_q, raw_match;
  logic                 key_clash, srch_go;
  logic [TILE_DEPTH-1:0] tile_vec [ROWS][COLS];

  cam_write_seq #(.KEY_W(KEY_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_wseq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_loc(wr_loc), .wr_key(wr_key),
    .mem_we(mem_we), .mem_key(mem_key), .mem_loc(mem_loc), .mem_bit(mem_bit),
    .loc_vld(loc_vld), .busy(busy), .pend_old(pend_old), .pend_new(pend_new)
  );

  assign key_clash  = busy && ((srch_key == pend_old) || (srch_key == pend_new));
  assign srch_ready = (!res_valid || res_ready) && !key_clash;
  assign srch_go    = srch_valid && srch_ready;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_we;
    assign row_we = mem_we && ((mem_loc >> TLOC_W) == IDX_W'(r));
    for (genvar c = 0; c < COLS; c++) begin : g_col
      cam_tile #(.SLICE_W(TILE_KEY_W), .DEPTH(TILE_DEPTH), .LOC_W(TLOC_W)) u_tile (
        .clk(clk), .rst_n(rst_n),
        .wr_en(row_we),
        .wr_key(mem_key[c*TILE_KEY_W +: TILE_KEY_W]),
        .wr_loc(mem_loc[TLOC_W-1:0]),
        .wr_bit(mem_bit),
        .rd_en(srch_go),
        .rd_key(srch_key[c*TILE_KEY_W +: TILE_KEY_W]),
        .rd_vec(tile_vec[r][c])
      );
    end
  end

  // AND across key slices, concatenate rows.
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      raw_match[r*TILE_DEPTH +: TILE_DEPTH] = '1;
      for (int c = 0; c < COLS; c++) begin
        raw_match[r*TILE_DEPTH +: TILE_DEPTH] =
          raw_match[r*TILE_DEPTH +: TILE_DEPTH] & tile_vec[r][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      vld_snap_q <= '0;
    end else begin
      if (srch_go) begin
        res_valid  <= 1'b1;
        vld_snap_q <= loc_vld;
      end else if (res_ready) begin
        res_valid  <= 1'b0;
      end
    end
  end

  assign res_match = raw_match & vld_snap_q;
  assign res_hit   = |res_match;

  cam_lowest_idx #(.N(NUM_WORDS), .IDX_W(IDX_W)) u_lowest (
    .vec(res_match), .idx(res_index)
  );

  AST_RES_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    srch_go |=> res_valid); // R3
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_match) && $stable(res_index))); // R9
  AST_NO_CLASH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_go && busy) |-> (srch_key != pend_old && srch_key != pend_new)); // R6
  AST_INDEX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> res_match[res_index]); // R4
endmodule

// File: tb/cam_tiled_lookup_bench.sv
module cam_tiled_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 16;
  localparam int NW = 64;
  localparam int IW = 6;

  logic          clk = 0, rst_n = 0;
  logic          wr_valid = 0, srch_valid = 0, res_ready = 1;
  logic [IW-1:0] wr_loc = '0;
  logic [KW-1:0] wr_key = '0, srch_key = '0;
  logic          wr_ready, srch_ready, res_valid, res_hit;
  logic [NW-1:0] res_match;
  logic [IW-1:0] res_index;

  int n_chk = 0, n_bad = 0;
  logic [KW-1:0] mkey [NW];
  bit            mvld [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_tiled_lookup #(.KEY_W(KW), .NUM_WORDS(NW)) u_cam_tiled_lookup (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_loc(wr_loc), .wr_key(wr_key),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_match(res_match), .res_hit(res_hit), .res_index(res_index)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NW-1:0] act, input logic [NW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] exp_vec(input logic [KW-1:0] k);
    logic [NW-1:0] v = '0;
    for (int i = 0; i < NW; i++) v[i] = mvld[i] && (mkey[i] == k);
    return v;
  endfunction

  function automatic logic [IW-1:0] low_idx(input logic [NW-1:0] v);
    logic [IW-1:0] ix = '0;
    for (int i = NW - 1; i >= 0; i--) if (v[i]) ix = IW'(i);
    return ix;
  endfunction

  task automatic do_write(input int loc, input logic [KW-1:0] key);
    @(negedge clk);
    wr_valid = 1; wr_loc = IW'(loc); wr_key = key;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 0;
    mkey[loc] = key; mvld[loc] = 1;
  endtask

  task automatic check_search(input logic [KW-1:0] key, input string req);
    logic [NW-1:0] e;
    @(negedge clk);
    srch_valid = 1; srch_key = key; res_ready = 1;
    while (!srch_ready) @(negedge clk);
    @(posedge clk); #1;
    srch_valid = 0;
    e = exp_vec(key);
    @(negedge clk);
    check(res_valid == 1'b1, "R3", "res_valid after search", NW'(res_valid), NW'(1));
    check(res_match == e, req, "match vector", res_match, e);
    check(res_hit == (e != 0), "R4", "hit flag", NW'(res_hit), NW'(e != 0));
    check(res_index == low_idx(e), "R4", "lowest index", NW'(res_index), NW'(low_idx(e)));
  endtask

  task automatic t_reset();
    check(res_valid == 0, "R1", "res_valid after reset", NW'(res_valid), 0);
    check(wr_ready == 1, "R1", "wr_ready after reset", NW'(wr_ready), 1);
    check(srch_ready == 1, "R1", "srch_ready after reset", NW'(srch_ready), 1);
    check_search(16'h0000, "R1");
    check_search(16'h1234, "R1");
  endtask

  task automatic t_basic();
    do_write(3, 16'h1234);
    check(wr_ready == 1, "R2", "wr_ready after fresh write", NW'(wr_ready), 1);
    check_search(16'h1234, "R2");
    do_write(9, 16'h1234);
    do_write(5, 16'h00ff);
    check_search(16'h1234, "R3");
    check_search(16'h00ff, "R3");
  endtask

  task automatic t_slices();
    check_search(16'h1235, "R7");
    check_search(16'h1334, "R7");
    check_search(16'h3412, "R7");
    check_search(16'hff00, "R7");
  endtask

  task automatic t_rows();
    do_write(40, 16'habcd);
    do_write(63, 16'habcd);
    check_search(16'habcd, "R8");
    do_write(0, 16'habcd);
    check_search(16'habcd, "R8");
  endtask

  task automatic t_rewrite();
    @(negedge clk);
    wr_valid = 1; wr_loc = IW'(9); wr_key = 16'h5555; res_ready = 1;
    @(posedge clk); #1;
    wr_valid = 0; srch_valid = 0;
    srch_key = 16'h1234; #1;
    check(srch_ready == 0, "R6", "stall on old key", NW'(srch_ready), 0);
    srch_key = 16'h5555; #1;
    check(srch_ready == 0, "R6", "stall on new key", NW'(srch_ready), 0);
    srch_key = 16'h00ff; #1;
    check(srch_ready == 1, "R6", "other key accepted", NW'(srch_ready), 1);
    check(wr_ready == 0, "R5", "wr_ready low in set cycle", NW'(wr_ready), 0);
    @(posedge clk); #1;
    check(wr_ready == 1, "R5", "wr_ready back high", NW'(wr_ready), 1);
    mkey[9] = 16'h5555;
    check_search(16'h1234, "R5");
    check_search(16'h5555, "R5");
  endtask

  task automatic t_backpressure();
    logic [NW-1:0] e;
    e = exp_vec(16'h00ff);
    @(negedge clk);
    res_ready = 0; srch_valid = 1; srch_key = 16'h00ff;
    @(posedge clk); #1;
    srch_valid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(res_valid == 1, "R9", "result held valid", NW'(res_valid), 1);
      check(srch_ready == 0, "R9", "srch_ready low while held", NW'(srch_ready), 0);
      check(res_match == e, "R9", "held match", res_match, e);
      check(res_index == low_idx(e), "R9", "held index", NW'(res_index), NW'(low_idx(e)));
    end
    res_ready = 1;
    @(posedge clk); #1;
    @(negedge clk);
    check(res_valid == 0, "R9", "result drained", NW'(res_valid), 0);
  endtask

  task automatic t_same_edge();
    @(negedge clk);
    wr_valid = 1; wr_loc = IW'(20); wr_key = 16'h7777;
    srch_valid = 1; srch_key = 16'h7777; res_ready = 1;
    @(posedge clk); #1;
    wr_valid = 0; srch_valid = 0;
    @(negedge clk);
    check(res_valid == 1, "R10", "same-edge result valid", NW'(res_valid), 1);
    check(res_hit == 0, "R10", "same-edge search sees old state", NW'(res_hit), 0);
    mkey[20] = 16'h7777; mvld[20] = 1;
    check_search(16'h7777, "R10");
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin mkey[i] = '0; mvld[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_slices();
    t_rows();
    t_rewrite();
    t_backpressure();
    t_same_edge();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule